// File: doc/BRIEF.md
# Multi-Layer Alpha Blending Compositor

This block builds one output video frame from a solid background and up to four layer inputs. It reads pixels in raster order, one beat per output pixel. Each beat carries one 32-bit lane per layer, and a lane holds that layer's pixel for the current output position. The block walks the frame with its own column and row counters. For each layer it decides whether the layer's rectangle covers the current position. It then passes the pixel through a cascade of four blend stages. The first destination is a background colour that fills the whole frame. Layer 0 is blended first, and each stage's result becomes the destination of the next, so layer 3 ends up on top.

Every stage blends with source-over arithmetic and can treat its source as straight or premultiplied alpha. Destination alpha accumulates as coverage. A stage whose layer is off, or whose rectangle misses the pixel, hands its destination on untouched. The block converts no formats. ARGB and AYUV pixels go through the same arithmetic, and the selected format only travels with the output as a tag. Frame size and layer geometry are clamped into legal ranges. All configuration is captured once per frame, when the frame's first pixel is accepted.

The pipeline advances as a whole under valid/ready flow control. Its latency is fixed, and back-pressure on the output stalls every stage.

Top module: `layer_compositor`

## Requirements
- R1: The frame width and height are each clamped to 1..8190 (0 counts as 1). A frame is width×height output beats. `out_sof` marks the first beat, `out_eol` marks the beat in column width−1, and `out_eof` marks the beat in the last column of the last row.
- R2: The first destination is the background: alpha 0xFF in bits [31:24] and `cfg_bg_color` in bits [23:0]. It applies at every position of the frame.
- R3: In a straight-alpha stage, each colour byte becomes sat(m(D,255−Sa) + m(S,Sa)). Here m(v,a) = floor((v·a+127)/255), sat() limits the result to 255, and Sa is source bits [31:24].
- R4: In a premultiplied stage (`cfg_layer_premul` bit k = 1), each colour byte becomes sat(m(D,255−Sa) + S). The source colour is not scaled by its alpha.
- R5: The output alpha byte is sat(m(Da,255−Sa) + Sa) in both modes. Because the background alpha is 0xFF, every output beat has alpha 0xFF.
- R6: Layer k feeds stage k, with k running from 0 to 3. Each stage's result is the next stage's destination, so a higher-numbered layer covers a lower-numbered one.
- R7: When `cfg_layer_en` bit k is 0, stage k passes its destination through unchanged and its lane value has no effect.
- R8: Layer k contributes only where px ≤ x < px+w and py ≤ y < py+h. Everywhere else stage k passes through, and the parts of the rectangle beyond the frame are dropped.
- R9: A layer's x position is clamped to width−1 and its y position to height−1, using the clamped frame size. Its width and height are clamped to 1..8190.
- R10: All configuration, including `cfg_fmt_yuv`, is sampled when the first beat of a frame is accepted. A change made after that point has no effect until the next frame. `out_fmt_yuv` carries the sampled format with every beat of the frame.
- R11: A beat accepted on clock edge N appears on the output after edge N+4 if the output is not stalled. While `out_valid` is high and `out_ready` is low, `out_pix` holds steady and `in_ready` is low.
- R12: Pixel layout: alpha is in bits [31:24] and the three components are in bits [23:16], [15:8] and [7:0]. Lane k of `in_pix` occupies bits [32k+31:32k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 13 | Frame width request |
| cfg_height | input | 13 | Frame height request |
| cfg_bg_color | input | 24 | Background colour |
| cfg_fmt_yuv | input | 1 | Format tag, 1 = AYUV, 0 = ARGB |
| cfg_layer_en | input | 4 | Per-layer enable |
| cfg_layer_premul | input | 4 | Per-layer premultiplied-source flag |
| cfg_layer_x | input | 52 | Layer x positions, 13 bits each |
| cfg_layer_y | input | 52 | Layer y positions, 13 bits each |
| cfg_layer_w | input | 52 | Layer widths, 13 bits each |
| cfg_layer_h | input | 52 | Layer heights, 13 bits each |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_pix | input | 128 | Four layer lanes for the current position |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take the beat |
| out_pix | output | 32 | Composed pixel |
| out_sof | output | 1 | First beat of frame |
| out_eol | output | 1 | Last beat of row |
| out_eof | output | 1 | Last beat of frame |
| out_fmt_yuv | output | 1 | Format tag sampled at frame start |

## Verification
A composed beat is due after the fifth register edge counted from its acceptance edge, provided the output is not stalled. The bench drives and samples on the falling edge. It records the loop cycle in which each beat is accepted and expects that beat on the port five loop cycles later; it checks this count only in frames where `out_ready` is held high. Under random back-pressure the bench matches beats in order through a queue of values it predicts itself. It computes each expected value at the moment of acceptance, from its own copy of the configuration taken at frame start, so configuration changes made mid-frame are judged against the frame-start values.

// File: rtl/lbc_pkg.sv
`timescale 1ns/1ps
package lbc_pkg;
  parameter int LYR     = 4;     // number of layer stages
  parameter int DW      = 13;    // coordinate width
  parameter int PW      = 32;    // pixel width
  parameter int CW      = 8;     // channel width
  parameter int DIM_MAX = 8190;  // largest legal frame or layer dimension
  localparam int NCH    = PW / CW;
  localparam int BGW    = PW - CW;

  typedef struct packed {
    logic [DW-1:0]           w;
    logic [DW-1:0]           h;
    logic [BGW-1:0]          bg;
    logic                    fmt;
    logic [LYR-1:0]          en;
    logic [LYR-1:0]          pm;
    logic [LYR-1:0][DW-1:0]  px;
    logic [LYR-1:0][DW-1:0]  py;
    logic [LYR-1:0][DW-1:0]  lw;
    logic [LYR-1:0][DW-1:0]  lh;
  } frame_cfg_t;

  typedef struct packed {
    logic                    vld;
    logic                    sof;
    logic                    eol;
    logic                    eof;
    logic                    fmt;
    logic [LYR-1:0]          hit;
    logic [LYR-1:0]          pm;
    logic [LYR-1:0][PW-1:0]  src;
    logic [PW-1:0]           dst;
  } beat_t;

  // rounded v*a/255
  function automatic logic [CW-1:0] scale8(input logic [CW-1:0] v, input logic [CW-1:0] a);
    logic [2*CW:0] t;
    logic [2*CW:0] q;
    t = (2*CW+1)'(v) * (2*CW+1)'(a) + (2*CW+1)'(127);
    q = (t + (2*CW+1)'(1) + (t >> CW)) >> CW;
    return q[CW-1:0];
  endfunction

  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CW] ? {CW{1'b1}} : s[CW-1:0];
  endfunction

  function automatic logic [DW-1:0] clamp_dim(input logic [DW-1:0] v);
    if (v == '0) return DW'(1);
    if (v > DW'(DIM_MAX)) return DW'(DIM_MAX);
    return v;
  endfunction

  function automatic logic [DW-1:0] clamp_pos(input logic [DW-1:0] p, input logic [DW-1:0] lim);
    return (p > lim - DW'(1)) ? lim - DW'(1) : p;
  endfunction
endpackage

// File: rtl/lbc_raster_tracker.sv
`timescale 1ns/1ps
module lbc_raster_tracker
  import lbc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                in_valid,
  input  logic [LYR*PW-1:0]   in_pix,
  input  logic [DW-1:0]       cfg_width,
  input  logic [DW-1:0]       cfg_height,
  input  logic [BGW-1:0]      cfg_bg_color,
  input  logic                cfg_fmt_yuv,
  input  logic [LYR-1:0]      cfg_layer_en,
  input  logic [LYR-1:0]      cfg_layer_premul,
  input  logic [LYR*DW-1:0]   cfg_layer_x,
  input  logic [LYR*DW-1:0]   cfg_layer_y,
  input  logic [LYR*DW-1:0]   cfg_layer_w,
  input  logic [LYR*DW-1:0]   cfg_layer_h,
  output beat_t               head_o
);
  logic [DW-1:0] x_q, y_q, x_d, y_d;
  frame_cfg_t    cur_q, live, eff;
  logic          at_start, row_end, last_row;

  // clamped live configuration
  always_comb begin
    live.w   = clamp_dim(cfg_width);
    live.h   = clamp_dim(cfg_height);
    live.bg  = cfg_bg_color;
    live.fmt = cfg_fmt_yuv;
    live.en  = cfg_layer_en;
    live.pm  = cfg_layer_premul;
    for (int k = 0; k < LYR; k++) begin
      live.px[k] = clamp_pos(cfg_layer_x[k*DW +: DW], live.w);
      live.py[k] = clamp_pos(cfg_layer_y[k*DW +: DW], live.h);
      live.lw[k] = clamp_dim(cfg_layer_w[k*DW +: DW]);
      live.lh[k] = clamp_dim(cfg_layer_h[k*DW +: DW]);
    end
  end

  // position bookkeeping and head beat
  always_comb begin
    at_start = (x_q == '0) && (y_q == '0);
    eff      = at_start ? live : cur_q;
    row_end  = (x_q == eff.w - DW'(1));
    last_row = (y_q == eff.h - DW'(1));
    x_d      = row_end ? '0 : x_q + DW'(1);
    y_d      = y_q;
    if (row_end) y_d = last_row ? '0 : y_q + DW'(1);

    head_o.vld = in_valid;
    head_o.sof = at_start;
    head_o.eol = row_end;
    head_o.eof = row_end && last_row;
    head_o.fmt = eff.fmt;
    head_o.pm  = eff.pm;
    head_o.dst = {{CW{1'b1}}, eff.bg};
    for (int k = 0; k < LYR; k++) begin
      head_o.src[k] = in_pix[k*PW +: PW];
      head_o.hit[k] = eff.en[k]
                    && (x_q >= eff.px[k])
                    && ({1'b0, x_q} < ({1'b0, eff.px[k]} + {1'b0, eff.lw[k]}))
                    && (y_q >= eff.py[k])
                    && ({1'b0, y_q} < ({1'b0, eff.py[k]} + {1'b0, eff.lh[k]}));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      cur_q <= '0;
    end else begin
      if (accept) begin
        x_q <= x_d;
        y_q <= y_d;
      end
      if (accept && at_start) cur_q <= live;
    end
  end
endmodule

// File: rtl/lbc_blend_stage.sv
`timescale 1ns/1ps
module lbc_blend_stage
  import lbc_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  beat_t d_i,
  output beat_t d_o
);
  beat_t          nxt;
  logic [PW-1:0]  src;
  logic [CW-1:0]  sa, inv;
  logic [PW-1:0]  mixed;

  always_comb begin
    src = d_i.src[IDX];
    sa  = src[PW-1 -: CW];
    inv = {CW{1'b1}} - sa;
    for (int c = 0; c < NCH - 1; c++) begin
      mixed[c*CW +: CW] = sat_add(scale8(d_i.dst[c*CW +: CW], inv),
                                  d_i.pm[IDX] ? src[c*CW +: CW]
                                              : scale8(src[c*CW +: CW], sa));
    end
    mixed[PW-1 -: CW] = sat_add(scale8(d_i.dst[PW-1 -: CW], inv), sa);
    nxt     = d_i;
    nxt.dst = d_i.hit[IDX] ? mixed : d_i.dst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_o <= '0;
    else if (adv) d_o <= nxt;
  end
endmodule

// File: rtl/layer_compositor.sv
`timescale 1ns/1ps
module layer_compositor
  import lbc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DW-1:0]       cfg_width,
  input  logic [DW-1:0]       cfg_height,
  input  logic [BGW-1:0]      cfg_bg_color,
  input  logic                cfg_fmt_yuv,
  input  logic [LYR-1:0]      cfg_layer_en,
  input  logic [LYR-1:0]      cfg_layer_premul,
  input  logic [LYR*DW-1:0]   cfg_layer_x,
  input  logic [LYR*DW-1:0]   cfg_layer_y,
  input  logic [LYR*DW-1:0]   cfg_layer_w,
  input  logic [LYR*DW-1:0]   cfg_layer_h,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LYR*PW-1:0]   in_pix,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [PW-1:0]       out_pix,
  output logic                out_sof,
  output logic                out_eol,
  output logic                out_eof,
  output logic                out_fmt_yuv
);
  beat_t head;
  beat_t stg [0:LYR];
  logic  adv, accept;

  always_comb begin
    adv    = !stg[LYR].vld || out_ready;
    accept = in_valid && adv;
  end

  lbc_raster_tracker u_track (
    .clk              (clk),
    .rst_n            (rst_n),
    .accept           (accept),
    .in_valid         (in_valid),
    .in_pix           (in_pix),
    .cfg_width        (cfg_width),
    .cfg_height       (cfg_height),
    .cfg_bg_color     (cfg_bg_color),
    .cfg_fmt_yuv      (cfg_fmt_yuv),
    .cfg_layer_en     (cfg_layer_en),
    .cfg_layer_premul (cfg_layer_premul),
    .cfg_layer_x      (cfg_layer_x),
    .cfg_layer_y      (cfg_layer_y),
    .cfg_layer_w      (cfg_layer_w),
    .cfg_layer_h      (cfg_layer_h),
    .head_o           (head)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else if (adv) stg[0] <= head;
  end

  for (genvar k = 0; k < LYR; k++) begin : g_stage
    lbc_blend_stage #(.IDX(k)) u_blend (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .d_i   (stg[k]),
      .d_o   (stg[k+1])
    );
  end

  always_comb begin
    in_ready    = adv;
    out_valid   = stg[LYR].vld;
    out_pix     = stg[LYR].dst;
    out_sof     = stg[LYR].sof;
    out_eol     = stg[LYR].eol;
    out_eof     = stg[LYR].eof;
    out_fmt_yuv = stg[LYR].fmt;
  end
endmodule

// File: rtl/lbc_checker.sv
`timescale 1ns/1ps
module lbc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_pix,
  input logic        out_eol,
  input logic        out_eof
);
  // R11: a stalled beat stays put
  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));

  // R11: input is refused while the output is stalled
  a_r11_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R5: coverage over an opaque background is always full
  a_r5_alpha_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_pix[31:24] == 8'hFF);

  // R1: the frame ends on a row end
  a_r1_eof_on_eol: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eof |-> out_eol);
endmodule

bind layer_compositor lbc_checker u_lbc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pix   (out_pix),
  .out_eol   (out_eol),
  .out_eof   (out_eof)
);

// File: tb/layer_compositor_tb_top.sv
`timescale 1ns/1ps
module layer_compositor_tb_top;
  logic          clk;
  logic          rst_n;
  logic [12:0]   cfg_width, cfg_height;
  logic [23:0]   cfg_bg_color;
  logic          cfg_fmt_yuv;
  logic [3:0]    cfg_layer_en, cfg_layer_premul;
  logic [51:0]   cfg_layer_x, cfg_layer_y, cfg_layer_w, cfg_layer_h;
  logic          in_valid, in_ready, out_valid, out_ready;
  logic [127:0]  in_pix;
  logic [31:0]   out_pix;
  logic          out_sof, out_eol, out_eof, out_fmt_yuv;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  int s_w, s_h, s_fmt;
  int s_bg;
  int s_en[4], s_pm[4], s_px[4], s_py[4], s_lw[4], s_lh[4];

  logic [35:0] q_exp[$];
  int          q_cyc[$];

  layer_compositor dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_bg_color(cfg_bg_color),
    .cfg_fmt_yuv(cfg_fmt_yuv), .cfg_layer_en(cfg_layer_en), .cfg_layer_premul(cfg_layer_premul),
    .cfg_layer_x(cfg_layer_x), .cfg_layer_y(cfg_layer_y), .cfg_layer_w(cfg_layer_w),
    .cfg_layer_h(cfg_layer_h),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .out_sof(out_sof), .out_eol(out_eol), .out_eof(out_eof), .out_fmt_yuv(out_fmt_yuv)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int clampd(input int v);
    if (v < 1) return 1;
    if (v > 8190) return 8190;
    return v;
  endfunction

  function automatic int mul(input int v, input int a);
    return (v * a + 127) / 255;
  endfunction

  function automatic int sat(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  task automatic take_snapshot();
    s_w   = clampd(int'(cfg_width));
    s_h   = clampd(int'(cfg_height));
    s_bg  = int'(cfg_bg_color);
    s_fmt = int'(cfg_fmt_yuv);
    for (int k = 0; k < 4; k++) begin
      s_en[k] = int'(cfg_layer_en[k]);
      s_pm[k] = int'(cfg_layer_premul[k]);
      s_px[k] = int'(cfg_layer_x[k*13 +: 13]);
      s_py[k] = int'(cfg_layer_y[k*13 +: 13]);
      if (s_px[k] > s_w - 1) s_px[k] = s_w - 1;
      if (s_py[k] > s_h - 1) s_py[k] = s_h - 1;
      s_lw[k] = clampd(int'(cfg_layer_w[k*13 +: 13]));
      s_lh[k] = clampd(int'(cfg_layer_h[k*13 +: 13]));
    end
  endtask

  function automatic logic [31:0] model(input int x, input int y, input logic [127:0] ln);
    int d[4];
    int sa, s;
    d[3] = 255;
    d[2] = (s_bg >> 16) & 255;
    d[1] = (s_bg >> 8) & 255;
    d[0] = s_bg & 255;
    for (int k = 0; k < 4; k++) begin
      if (s_en[k] != 0 && x >= s_px[k] && x < s_px[k] + s_lw[k]
          && y >= s_py[k] && y < s_py[k] + s_lh[k]) begin
        sa = int'(ln[k*32 + 24 +: 8]);
        for (int c = 0; c < 3; c++) begin
          s    = int'(ln[k*32 + c*8 +: 8]);
          d[c] = sat(mul(d[c], 255 - sa) + (s_pm[k] != 0 ? s : mul(s, sa)));
        end
        d[3] = sat(mul(d[3], 255 - sa) + sa);
      end
    end
    return {d[3][7:0], d[2][7:0], d[1][7:0], d[0][7:0]};
  endfunction

  function automatic logic [31:0] rand_pix();
    logic [7:0] a;
    int sel;
    sel = int'($urandom % 4);
    a = (sel == 0) ? 8'h00 : (sel == 1) ? 8'hFF : 8'($urandom);
    return {a, 24'($urandom)};
  endfunction

  task automatic rand_cfg(input int maxw, input int maxh);
    cfg_width        = 13'(int'($urandom % (maxw + 1)));
    cfg_height       = 13'(int'($urandom % (maxh + 1)));
    cfg_bg_color     = 24'($urandom);
    cfg_fmt_yuv      = 1'($urandom);
    cfg_layer_en     = 4'($urandom);
    cfg_layer_premul = 4'($urandom);
    for (int k = 0; k < 4; k++) begin
      cfg_layer_x[k*13 +: 13] = 13'($urandom % 16);
      cfg_layer_y[k*13 +: 13] = 13'($urandom % 9);
      cfg_layer_w[k*13 +: 13] = 13'($urandom % 11);
      cfg_layer_h[k*13 +: 13] = 13'($urandom % 7);
    end
  endtask

  // run one frame; tag names the requirements the pixel compares cover
  task automatic run_frame(input string tag, input bit chk_lat, input bit bp, input bit mid_change);
    int npix, sent, recv, x, y;
    logic [127:0] lanes;
    logic [35:0]  e;
    int           c0;
    bit fire_in, fire_out;
    take_snapshot();
    npix = s_w * s_h;
    sent = 0;
    recv = 0;
    for (int k = 0; k < 4; k++) lanes[k*32 +: 32] = rand_pix();
    while (recv < npix) begin
      @(negedge clk);
      out_ready = bp ? (($urandom % 4) != 0) : 1'b1;
      if (sent < npix) begin
        in_valid = bp ? (($urandom % 3) != 0) : 1'b1;
        in_pix   = lanes;
      end else begin
        in_valid = 1'b0;
      end
      #1;
      fire_in  = in_valid && in_ready;
      fire_out = out_valid && out_ready;
      if (fire_out) begin
        e  = q_exp.pop_front();
        c0 = q_cyc.pop_front();
        chk({tag, " pixel"}, 64'(out_pix), 64'(e[31:0]));
        chk("R5 alpha", 64'(out_pix[31:24]), 64'hFF);
        chk("R1 framing", 64'({out_sof, out_eol, out_eof}), 64'(e[34:32]));
        chk("R10 fmt tag", 64'(out_fmt_yuv), 64'(e[35]));
        if (chk_lat) chk("R11 latency", 64'(cyc - c0), 64'd5);
        recv++;
      end
      if (fire_in) begin
        x = sent % s_w;
        y = sent / s_w;
        e[31:0] = model(x, y, lanes);
        e[34]   = (sent == 0);
        e[33]   = (x == s_w - 1);
        e[32]   = (sent == npix - 1);
        e[35]   = s_fmt[0];
        q_exp.push_back(e);
        q_cyc.push_back(cyc);
        sent++;
        for (int k = 0; k < 4; k++) lanes[k*32 +: 32] = rand_pix();
        if (mid_change && sent == 2) rand_cfg(12, 6);
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    cyc++;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_pix = '0;
    cfg_width = '0; cfg_height = '0; cfg_bg_color = '0; cfg_fmt_yuv = 1'b0;
    cfg_layer_en = '0; cfg_layer_premul = '0;
    cfg_layer_x = '0; cfg_layer_y = '0; cfg_layer_w = '0; cfg_layer_h = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R11 reset out_valid", 64'(out_valid), 64'd0);
    chk("R11 reset in_ready", 64'(in_ready), 64'd1);

    // background only, every layer off (lanes random and must be ignored)
    cfg_width = 13'd8; cfg_height = 13'd5; cfg_bg_color = 24'h3C7A11; cfg_fmt_yuv = 1'b1;
    cfg_layer_en = 4'b0000; cfg_layer_premul = 4'b1010;
    for (int k = 0; k < 4; k++) begin
      cfg_layer_x[k*13 +: 13] = 13'd0; cfg_layer_y[k*13 +: 13] = 13'd0;
      cfg_layer_w[k*13 +: 13] = 13'd8; cfg_layer_h[k*13 +: 13] = 13'd5;
    end
    run_frame("R2 R7 background", 1'b1, 1'b0, 1'b0);

    // full overlap, all enabled: stage order and both alpha modes
    cfg_layer_en = 4'b1111; cfg_layer_premul = 4'b0110;
    run_frame("R3 R4 R6 R12 stacked", 1'b1, 1'b0, 1'b0);

    // windowing with positions and sizes past the edges
    cfg_width = 13'd10; cfg_height = 13'd6; cfg_layer_en = 4'b1111; cfg_layer_premul = 4'b0001;
    cfg_layer_x[0 +: 13] = 13'd2;  cfg_layer_w[0 +: 13] = 13'd3; cfg_layer_y[0 +: 13] = 13'd1; cfg_layer_h[0 +: 13] = 13'd2;
    cfg_layer_x[13 +: 13] = 13'd8; cfg_layer_w[13 +: 13] = 13'd9; cfg_layer_y[13 +: 13] = 13'd4; cfg_layer_h[13 +: 13] = 13'd9;
    cfg_layer_x[26 +: 13] = 13'd40; cfg_layer_w[26 +: 13] = 13'd0; cfg_layer_y[26 +: 13] = 13'd40; cfg_layer_h[26 +: 13] = 13'd0;
    cfg_layer_x[39 +: 13] = 13'd0; cfg_layer_w[39 +: 13] = 13'd10; cfg_layer_y[39 +: 13] = 13'd3; cfg_layer_h[39 +: 13] = 13'd1;
    run_frame("R8 R9 window", 1'b0, 1'b1, 1'b0);

    // configuration changed after the first beat of a frame
    rand_cfg(12, 6);
    run_frame("R10 mid-frame change", 1'b0, 1'b1, 1'b1);

    // zero dimensions clamp to a single pixel
    cfg_width = 13'd0; cfg_height = 13'd0; cfg_layer_en = 4'b0001;
    cfg_layer_x[0 +: 13] = 13'd5; cfg_layer_y[0 +: 13] = 13'd5;
    run_frame("R1 R9 one-pixel frame", 1'b1, 1'b0, 1'b0);

    // oversize width clamps to 8190, layer pushed to the last column
    cfg_width = 13'd8191; cfg_height = 13'd0; cfg_layer_en = 4'b0100; cfg_layer_premul = 4'b0100;
    cfg_layer_x[26 +: 13] = 13'd8191; cfg_layer_w[26 +: 13] = 13'd5;
    cfg_layer_y[26 +: 13] = 13'd3;    cfg_layer_h[26 +: 13] = 13'd1;
    run_frame("R1 R9 wide frame", 1'b1, 1'b0, 1'b0);

    // random frames with back-pressure
    for (int f = 0; f < 30; f++) begin
      rand_cfg(12, 6);
      run_frame("R3 R4 R6 R7 R8 random", 1'b0, 1'b1, (f % 5) == 4);
    end

    chk("R11 queue drained", 64'(q_exp.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule